// File: doc/BRIEF.md
# Four-Mode Serial Master with Late-Capture Option

This block is a byte-wide synchronous serial master. It shifts an 8-bit word out on `mosi`, most significant bit first, and collects 8 bits from `miso` at the same time. It drives an active-low select, `cs_n`, and a serial clock, `sclk`. The serial clock comes from a divider of the system clock. Its half-period is a whole number of system clocks, so the high and low phases are always the same length.

A two-bit mode number sets the serial clock's idle level and the edge on which data is launched. Bit 1 is the idle polarity and bit 0 is the phase. With phase 0, the first bit is on the line before the first edge. With phase 1, the first bit is launched on the first edge.

A separate bit selects late capture. With late capture off, `miso` is captured on the edge opposite the launch edge. With late capture on, each `miso` bit is captured on the edge that launches the next `mosi` bit. This gives the slave almost a full serial period to drive its output.

The host sees a simple handshake. It raises `start` while `ready` is high, then waits for the one-cycle `done` pulse, which comes with a valid `rx_byte`.

Top module: `spi_late_master`

## Requirements
- R1: `cfg_mode[1]` is the clock polarity and `cfg_mode[0]` is the clock phase. While idle, `sclk` equals the `cfg_mode[1]` value present at the previous clock edge. During a transfer, `sclk` rests at the latched polarity.
- R2: Each serial clock phase lasts H system clocks, where H is `cfg_half`, and a value of 0 is treated as 1. Counting from the cycle in which `start` is accepted, `sclk` equals polarity XOR (min(floor(k/H),16) mod 2) at k system clocks after acceptance.
- R3: `cs_n` falls in the clock in which `start` is accepted. It rises E·H clocks later. E is 17, or 18 when phase is 1 and late capture is on.
- R4: `mosi` carries bit 7−i of the transmit byte. Bit 0 appears when `cs_n` falls. Bit i (i≥1) is launched at half-period tick 2i with phase 0, or at tick 2i+1 with phase 1. Between launches, `mosi` is stable.
- R5: With late capture off, bit i of the received stream is captured at tick 2i+1+phase.
- R6: With late capture on, bit i is captured at tick 2i+2+phase. With phase 1, the last bit is captured at the extra tick 17, one half-period after the last clock edge.
- R7: `done` is high for exactly one clock, in the same clock that `cs_n` rises. At that clock, `rx_byte` holds the received byte, first-received bit in bit 7. It holds that value until the next `done`.
- R8: `ready` is low exactly while a transfer is running. `start` is ignored while `ready` is low. Mode, late-capture bit, half-period and transmit byte are latched only on acceptance, and later changes do not affect the running transfer.
- R9: After reset, `cs_n`=1, `sclk`=0, `done`=0, `ready`=1 and `rx_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (taken when ready is high) |
| cfg_mode | input | 2 | Bit 1 polarity, bit 0 phase |
| cfg_late | input | 1 | 1 selects late capture |
| cfg_half | input | HALF_W | Serial clock half-period in system clocks (0 acts as 1) |
| tx_byte | input | DATA_W | Byte to send |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_byte | output | DATA_W | Last received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
Every output is a register, so each result shows up one system clock after the edge that causes it. `cs_n`, `ready` and the first `mosi` bit change in the clock that accepts `start`. Half-period tick n lands exactly n·H clocks after acceptance. `done` and the new `rx_byte` land E·H clocks after acceptance. The bench keeps its own count of clocks since acceptance and, from that count, works out every expected level for each cycle. It samples all outputs on the falling system clock edge and compares them there. The slave model in the bench holds back its `miso` changes by a set number of clocks. With that delay, only capture on the late edge can gather the right byte in late-capture runs, while runs with no delay exercise standard capture.

// File: rtl/spi_lm_pkg.sv
package spi_lm_pkg;

  // Last half-period tick of a transfer: one half-period after the final
  // clock edge, plus one more when late capture runs past the edges.
  function automatic int end_tick(input int bits, input logic cpha, input logic late);
    return 2 * bits + 1 + ((cpha && late) ? 1 : 0);
  endfunction

  // Tick at which a new transmit bit is placed on the line (first bit excluded).
  function automatic logic is_launch(input int n, input int bits, input logic cpha);
    int off;
    off = cpha ? 1 : 0;
    return (n >= 2 + off) && (n <= 2 * bits - 2 + off) && (((n - off) % 2) == 0);
  endfunction

  // Tick at which a receive bit is taken.
  function automatic logic is_capture(input int n, input int bits, input logic cpha,
                                      input logic late);
    int k;
    k = n - 1 - (cpha ? 1 : 0) - (late ? 1 : 0);
    return (k >= 0) && ((k % 2) == 0) && ((k / 2) < bits);
  endfunction

endpackage

// File: rtl/spi_lm_clkdiv.sv
module spi_lm_clkdiv #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [HALF_W-1:0] load_half,
  input  logic [HALF_W-1:0] run_half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  function automatic logic [HALF_W-1:0] top_of(input logic [HALF_W-1:0] h);
    return (h == '0) ? '0 : h - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= top_of(load_half);
    else if (run) begin
      if (cnt == '0)   cnt <= top_of(run_half);
      else             cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/spi_lm_seq.sv
module spi_lm_seq
  import spi_lm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_late,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic              tick,
  output logic              accept,
  output logic              busy,
  output logic [HALF_W-1:0] half_q,
  output logic              launch,
  output logic              capture,
  output logic              finish,
  output logic              sclk,
  output logic              cs_n,
  output logic              done
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES + 3);

  logic [CNT_W-1:0] tcnt;
  logic [CNT_W-1:0] nxt;
  logic             cpol_q, cpha_q, late_q;

  assign accept  = start && !busy;
  assign nxt     = tcnt + 1'b1;
  assign launch  = tick && is_launch(int'(nxt), DATA_W, cpha_q);
  assign capture = tick && is_capture(int'(nxt), DATA_W, cpha_q, late_q);
  assign finish  = tick && (int'(nxt) == end_tick(DATA_W, cpha_q, late_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tcnt   <= '0;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      done   <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      late_q <= 1'b0;
      half_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cfg_mode[1];
        if (start) begin
          busy   <= 1'b1;
          tcnt   <= '0;
          cs_n   <= 1'b0;
          cpol_q <= cfg_mode[1];
          cpha_q <= cfg_mode[0];
          late_q <= cfg_late;
          half_q <= cfg_half;
        end
      end else if (tick) begin
        tcnt <= nxt;
        if (int'(nxt) <= EDGES) sclk <= ~sclk;
        if (finish) begin
          busy <= 1'b0;
          cs_n <= 1'b1;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_lm_shift.sv
module spi_lm_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              launch,
  input  logic              capture,
  input  logic              finish,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
    end else begin
      if (load)         tx_sr <= load_data;
      else if (launch)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (capture)      rx_sr <= {rx_sr[DATA_W-2:0], miso};
      if (finish)       rx_byte <= rx_sr;
    end
  end

  assign mosi = tx_sr[DATA_W-1];
endmodule

// File: rtl/spi_late_master.sv
module spi_late_master #(
  parameter int DATA_W = 8,
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_late,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic              tick_w, accept_w, busy_w, launch_w, capture_w, finish_w;
  logic [HALF_W-1:0] half_q;

  spi_lm_clkdiv #(.HALF_W(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept_w), .run(busy_w),
    .load_half(cfg_half), .run_half(half_q), .tick(tick_w)
  );

  spi_lm_seq #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_late(cfg_late), .cfg_half(cfg_half), .tick(tick_w),
    .accept(accept_w), .busy(busy_w), .half_q(half_q), .launch(launch_w),
    .capture(capture_w), .finish(finish_w), .sclk(sclk), .cs_n(cs_n),
    .done(done)
  );

  spi_lm_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept_w), .load_data(tx_byte),
    .launch(launch_w), .capture(capture_w), .finish(finish_w),
    .miso(miso), .mosi(mosi), .rx_byte(rx_byte)
  );

  assign ready = !busy_w;
endmodule

// File: rtl/spi_lm_checker.sv
module spi_lm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       ready,
  input logic       done,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n,
  input logic       tick,
  input logic       launch
);
  // R1: idle clock level tracks the polarity input
  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ready && $past(ready)) |-> (sclk == $past(cfg_mode[1])));

  // R2: serial clock moves only on a half-period tick
  assert_edge_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && (sclk != $past(sclk))) |-> $past(tick));

  // R4: data out holds between launches
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$past(launch)) |-> $stable(mosi));

  // R7: done is a single pulse aligned with select release
  assert_done_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: select active implies not ready
  assert_busy_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ready);
endmodule

bind spi_late_master spi_lm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .ready(ready), .done(done),
  .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .tick(tick_w), .launch(launch_w)
);

// File: tb/sim_spi_late_master.sv
`timescale 1ns/1ps
module sim_spi_late_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_late = 1'b0;
  logic [7:0] cfg_half = 8'd2;
  logic [7:0] tx_byte = 8'h00;
  logic       ready, done, sclk, mosi, cs_n;
  logic       miso = 1'b0;
  logic [7:0] rx_byte;

  always #2.5 clk = ~clk;

  spi_late_master #(.DATA_W(8), .HALF_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_late(cfg_late), .cfg_half(cfg_half), .tx_byte(tx_byte),
    .ready(ready), .done(done), .rx_byte(rx_byte), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Slave model settings
  logic       s_cpol = 0, s_cpha = 0;
  logic [7:0] s_byte = 0;
  int         s_dly = 0;

  // Reference model state
  logic       m_busy = 0, m_cs = 1, m_sclk = 0, m_done = 0;
  logic       m_cpol = 0, m_cpha = 0, m_late = 0;
  logic [7:0] m_tx = 0, m_sb = 0, m_rx = 0;
  int         m_c = 0, m_h = 1, m_e = 17, m_idx = 0;

  always @(posedge clk) begin
    int n;
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_cs = 1; m_sclk = 0; m_done = 0; m_rx = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        m_sclk = cfg_mode[1];
        if (start) begin
          m_busy = 1; m_cs = 0; m_c = 0;
          m_cpol = cfg_mode[1]; m_cpha = cfg_mode[0]; m_late = cfg_late;
          m_h = (cfg_half == 0) ? 1 : int'(cfg_half);
          m_tx = tx_byte; m_sb = s_byte;
          m_e = 17 + ((m_cpha && m_late) ? 1 : 0);
          m_idx = 0;
        end
      end else begin
        m_c++;
        n = m_c / m_h;
        m_sclk = m_cpol ^ ((n > 16 ? 16 : n) % 2 == 1);
        if (m_cpha) m_idx = (n == 0) ? 0 : (n - 1) / 2;
        else        m_idx = n / 2;
        if (m_idx > 7) m_idx = 7;
        if (n == m_e) begin
          m_busy = 0; m_cs = 1; m_done = 1; m_rx = m_sb;
        end
      end
    end
  end

  // Slave: present bits on its launch edges, delayed by s_dly clocks
  logic [15:0] pipe = 0;
  logic        s_cur = 0, s_prev = 0, s_act = 0;
  int          s_k = 0;
  always @(negedge clk) begin
    if (cs_n) s_act = 0;
    else if (!s_act) begin
      s_act = 1; s_k = 0; s_prev = sclk;
      if (!s_cpha) begin s_cur = s_byte[7]; s_k = 1; end
    end else if (sclk != s_prev) begin
      if ((s_cpha ? (s_prev == s_cpol) : (s_prev != s_cpol)) && s_k < 8) begin
        s_cur = s_byte[7 - s_k]; s_k++;
      end
      s_prev = sclk;
    end
    pipe = {pipe[14:0], s_cur};
    miso = pipe[s_dly];
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(cs_n == 1, "R9 cs_n", cs_n, 1);
      chk(sclk == 0, "R9 sclk", sclk, 0);
      chk(done == 0, "R9 done", done, 0);
      chk(ready == 1, "R9 ready", ready, 1);
      chk(rx_byte == 0, "R9 rx_byte", rx_byte, 0);
    end else begin
      chk(cs_n == m_cs, "R3 cs_n", cs_n, m_cs);
      if (m_busy || m_done) chk(sclk == m_sclk, "R2 sclk", sclk, m_sclk);
      else                  chk(sclk == m_sclk, "R1 sclk idle", sclk, m_sclk);
      chk(done == m_done, "R7 done", done, m_done);
      chk(ready == !m_busy, "R8 ready", ready, !m_busy);
      if (m_late) chk(rx_byte == m_rx, "R6 rx_byte", rx_byte, m_rx);
      else        chk(rx_byte == m_rx, "R5 rx_byte", rx_byte, m_rx);
      if (!m_cs) chk(mosi == m_tx[7 - m_idx], "R4 mosi", mosi, m_tx[7 - m_idx]);
    end
  end

  task automatic xfer(input logic [1:0] mode, input logic late, input logic [7:0] half,
                      input logic [7:0] tx, input logic [7:0] sb, input int dly,
                      input bit disturb);
    while (!ready) begin @(posedge clk); #1; end
    s_cpol = mode[1]; s_cpha = mode[0]; s_byte = sb; s_dly = dly;
    cfg_mode = mode; cfg_late = late; cfg_half = half; tx_byte = tx; start = 1;
    @(posedge clk); #1 start = 0;
    if (disturb) begin
      repeat (5) begin @(posedge clk); #1; end
      cfg_mode = ~mode; cfg_late = ~late; cfg_half = half + 8'd3; tx_byte = ~tx;
      start = 1;   // R8: ignored while busy
      @(posedge clk); #1 start = 0;
    end
    forever begin @(posedge clk); #1; if (done) break; end
    repeat (3) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1;
    repeat (3) begin @(posedge clk); #1; end
    cfg_mode = 2'd2;                      // R1 idle level follows polarity
    repeat (3) begin @(posedge clk); #1; end
    // R5 standard capture, all modes, various half-periods
    xfer(2'd0, 0, 8'd2, 8'hA5, 8'h3C, 0, 0);
    xfer(2'd1, 0, 8'd3, 8'h5A, 8'hC3, 0, 0);
    xfer(2'd2, 0, 8'd0, 8'h81, 8'h7E, 0, 0);  // R2 zero half acts as one
    xfer(2'd3, 0, 8'd4, 8'hF0, 8'h0F, 0, 0);
    xfer(2'd0, 0, 8'd1, 8'h00, 8'hFF, 0, 0);
    // R6 late capture with a slow slave
    xfer(2'd0, 1, 8'd3, 8'h96, 8'hB2, 4, 0);
    xfer(2'd1, 1, 8'd3, 8'h69, 8'h4D, 4, 0);  // extra half-period
    xfer(2'd2, 1, 8'd4, 8'hCC, 8'h1E, 5, 0);
    xfer(2'd3, 1, 8'd4, 8'h33, 8'hE1, 5, 0);
    // R8 configuration changes and start during a transfer
    xfer(2'd1, 1, 8'd3, 8'h2B, 8'hD4, 4, 1);
    xfer(2'd2, 0, 8'd2, 8'hE7, 8'h18, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule